// File: doc/BRIEF.md
# I2C Three-Byte Command-Word Receiver

This block is the write-only serial front end of a four-channel converter target on an I2C bus. It samples the bus clock and data lines with a fast system clock, finds START and STOP conditions, and compares the 7-bit address in the first byte against two values. One is the address set on the `dev_addr_i` inputs. The other is a fixed broadcast address, which lets one transfer reach every such target on the bus.

Once the address matches on a write, the block takes in exactly three data bytes and pulls SDA low to acknowledge each of them. When the third byte is complete, it presents one command word for a single system-clock cycle: a 4-bit command, a 4-bit channel selector and the converter code. The code is taken from the top of the 16-bit data field. The block never acknowledges a read or any byte after the third. A transfer that is cut short by STOP or by a repeated START produces no word.

Top module: `i2c_cmd_word_rx`

## Requirements
- R1: After reset, `sda_pull_o` and `word_valid_o` are 0 and `cmd_o`, `chan_o` and `code_o` are all zero.
- R2: A first byte whose upper seven bits equal `dev_addr_i` and whose bit 0 (R/W) is 0 is acknowledged: `sda_pull_o` is 1 during the ninth SCL high phase.
- R3: A first byte whose upper seven bits equal the `GLOBAL_ADDR` parameter (default 7'b1110011) and whose bit 0 is 0 is acknowledged. This holds whatever the value of `dev_addr_i`.
- R4: A first byte that matches neither address is not acknowledged. No later byte in that transfer is acknowledged, and no word is issued.
- R5: A first byte with bit 0 = 1 (read) is never acknowledged, even when its address matches.
- R6: After a matched write address, the first, second and third data bytes are each acknowledged in their ninth clock. The fourth and any later bytes are not.
- R7: When the third data byte is complete, `word_valid_o` is 1 for exactly one system clock. With that pulse, `cmd_o` = byte1[7:4], `chan_o` = byte1[3:0], and `code_o` = the upper `RES_BITS` bits of {byte2, byte3}. The bytes arrive MSB first.
- R8: A STOP, or a repeated START, before the third data byte discards the partial word and issues no pulse. A new transfer that follows is received normally.
- R9: Bytes after the third do not produce a second word pulse.
- R10: `sda_pull_o` changes only while the synchronised SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_addr_i | input | 7 | Selectable 7-bit device address |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| word_valid_o | output | 1 | One-cycle strobe: a complete word is present |
| cmd_o | output | 4 | Command nibble of the word |
| chan_o | output | 4 | Channel selector nibble of the word |
| code_o | output | RES_BITS | Converter code, from the top of the data field |

## Verification
The bench builds the block with `RES_BITS` = 12. The lowest nibble of the third byte is then a don't-care, and the bench checks that it is dropped from `code_o`. `GLOBAL_ADDR` keeps its default value. `dev_addr_i` is changed during the run, so the bench can show that the broadcast match is independent of the selectable address and that the previous device address is then refused. SCL runs at one fortieth of the system clock, which leaves room to observe the acknowledge slot, partial transfers and over-long transfers.

// File: rtl/i2c_cmd_word_rx.sv
module i2c_cmd_word_rx #(
  parameter logic [6:0] GLOBAL_ADDR = 7'b1110011,
  parameter int         RES_BITS    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [6:0]          dev_addr_i,
  output logic                sda_pull_o,
  output logic                word_valid_o,
  output logic [3:0]          cmd_o,
  output logic [3:0]          chan_o,
  output logic [RES_BITS-1:0] code_o
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;
  st_t        st;
  logic [3:0] bitcnt;
  logic [1:0] nbytes;
  logic [7:0] shreg, b0, b1;
  logic [15:0] dword;
  logic       addr_hit;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign dword     = {b1, shreg};
  assign addr_hit  = ~shreg[0] &
                     ((shreg[7:1] == dev_addr_i) || (shreg[7:1] == GLOBAL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy       <= 2'b11;
      sda_sy       <= 2'b11;
      scl_d        <= 1'b1;
      sda_d        <= 1'b1;
      st           <= S_IDLE;
      bitcnt       <= '0;
      nbytes       <= '0;
      shreg        <= '0;
      b0           <= '0;
      b1           <= '0;
      sda_pull_o   <= 1'b0;
      word_valid_o <= 1'b0;
      cmd_o        <= '0;
      chan_o       <= '0;
      code_o       <= '0;
    end else begin
      scl_sy       <= {scl_sy[0], scl_i};
      sda_sy       <= {sda_sy[0], sda_i};
      scl_d        <= scl_s;
      sda_d        <= sda_s;
      word_valid_o <= 1'b0;
      if (start_det) begin
        st         <= S_ADDR;
        bitcnt     <= '0;
        nbytes     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        st         <= S_IDLE;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (st == S_ADDR || st == S_DATA) begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (st == S_ADDR) begin
            if (addr_hit) sda_pull_o <= 1'b1;
            else          st <= S_SKIP;
          end else if (nbytes != 2'd3) begin
            sda_pull_o <= 1'b1;
            nbytes     <= nbytes + 2'd1;
            case (nbytes)
              2'd0:    b0 <= shreg;
              2'd1:    b1 <= shreg;
              default: begin
                cmd_o        <= b0[7:4];
                chan_o       <= b0[3:0];
                code_o       <= dword[15 -: RES_BITS];
                word_valid_o <= 1'b1;
              end
            endcase
          end
        end else if (scl_fall && bitcnt == 4'd9) begin
          bitcnt     <= '0;
          sda_pull_o <= 1'b0;
          if (st == S_ADDR) st <= S_DATA;
        end
      end
    end
  end

endmodule

module i2c_cmd_word_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_pull_o,
  input logic       word_valid_o,
  input logic [3:0] bitcnt,
  input logic [1:0] nbytes
);

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  p_no_early_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> nbytes == 2'd3);

  p_pull_in_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> bitcnt == 4'd9);

  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> (!scl_s || $past(start_det || stop_det)));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull_o && !word_valid_o));

endmodule

bind i2c_cmd_word_rx i2c_cmd_word_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull_o(sda_pull_o), .word_valid_o(word_valid_o),
  .bitcnt(bitcnt), .nbytes(nbytes)
);

// File: tb/i2c_cmd_word_rx_tb.sv
`timescale 1ns/1ps
module i2c_cmd_word_rx_tb;
  localparam int RB = 12;
  localparam int Q  = 10;
  localparam logic [6:0] GADDR = 7'b1110011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic [6:0] dev_addr = 7'h21;
  logic sda_pull, wvalid;
  logic [3:0] cmd, chan;
  logic [RB-1:0] code;
  int tests = 0, fails = 0, pulses = 0, pushed = 0;
  logic [23:0] sb[$];

  always #2 clk = ~clk;

  i2c_cmd_word_rx #(.GLOBAL_ADDR(GADDR), .RES_BITS(RB)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(msda & ~sda_pull),
    .dev_addr_i(dev_addr), .sda_pull_o(sda_pull), .word_valid_o(wvalid),
    .cmd_o(cmd), .chan_o(chan), .code_o(code));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; waitq(Q); scl = 1'b1; waitq(Q);
    msda = 1'b0; waitq(Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; waitq(Q); scl = 1'b1; waitq(Q); msda = 1'b1; waitq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; waitq(Q); scl = 1'b1; waitq(2*Q); scl = 1'b0; waitq(Q);
    end
    msda = 1'b1; waitq(Q); scl = 1'b1; waitq(Q);
    check(req, {31'd0, sda_pull}, {31'd0, exp_ack});
    waitq(Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic expect_word(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    sb.push_back({b0, b1, b2});
    pushed++;
  endtask

  always @(negedge clk) begin
    if (wvalid) begin
      pulses++;
      if (sb.size() == 0) begin
        check("R8/R9 unexpected word", 32'd1, 32'd0);
      end else begin
        logic [23:0] e;
        logic [15:0] d;
        e = sb.pop_front();
        d = e[15:0];
        check("R7 cmd", {28'd0, cmd}, {28'd0, e[23:20]});
        check("R7 chan", {28'd0, chan}, {28'd0, e[19:16]});
        check("R7 code", {20'd0, code}, {20'd0, d[15 -: RB]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    waitq(5);
    check("R1 pull", {31'd0, sda_pull}, 0);
    check("R1 valid", {31'd0, wvalid}, 0);
    check("R1 word", {20'd0, cmd, chan, code}, 0);
    rst_n = 1'b1; waitq(5);

    // R2 own address, R6 three acks, R7 fields
    expect_word(8'h3A, 8'hBE, 8'hEF);
    bus_start();
    send_byte({7'h21, 1'b0}, 1'b1, "R2 own addr");
    send_byte(8'h3A, 1'b1, "R6 byte1");
    send_byte(8'hBE, 1'b1, "R6 byte2");
    send_byte(8'hEF, 1'b1, "R6 byte3");
    bus_stop();

    // R3 global address
    expect_word(8'h0F, 8'h12, 8'h34);
    bus_start();
    send_byte({GADDR, 1'b0}, 1'b1, "R3 global addr");
    send_byte(8'h0F, 1'b1, "R6 byte1");
    send_byte(8'h12, 1'b1, "R6 byte2");
    send_byte(8'h34, 1'b1, "R6 byte3");
    bus_stop();

    // R4 mismatch
    bus_start();
    send_byte({7'h22, 1'b0}, 1'b0, "R4 mismatch addr");
    send_byte(8'h11, 1'b0, "R4 data after mismatch");
    send_byte(8'h22, 1'b0, "R4 data after mismatch");
    send_byte(8'h33, 1'b0, "R4 data after mismatch");
    bus_stop();

    // R5 reads refused
    bus_start();
    send_byte({7'h21, 1'b1}, 1'b0, "R5 read own");
    bus_stop();
    bus_start();
    send_byte({GADDR, 1'b1}, 1'b0, "R5 read global");
    bus_stop();

    // R6/R9 over-long transfer
    expect_word(8'hC5, 8'hA5, 8'h5A);
    bus_start();
    send_byte({7'h21, 1'b0}, 1'b1, "R2 own addr");
    send_byte(8'hC5, 1'b1, "R6 byte1");
    send_byte(8'hA5, 1'b1, "R6 byte2");
    send_byte(8'h5A, 1'b1, "R6 byte3");
    send_byte(8'hFF, 1'b0, "R6 byte4 nack");
    send_byte(8'h00, 1'b0, "R9 byte5 nack");
    bus_stop();

    // R8 partial then STOP
    bus_start();
    send_byte({7'h21, 1'b0}, 1'b1, "R2 own addr");
    send_byte(8'h77, 1'b1, "R6 byte1");
    send_byte(8'h88, 1'b1, "R6 byte2");
    bus_stop();

    // R8 partial then repeated START
    bus_start();
    send_byte({GADDR, 1'b0}, 1'b1, "R3 global addr");
    send_byte(8'h99, 1'b1, "R6 byte1");
    expect_word(8'h6B, 8'h80, 8'h01);
    bus_start();
    send_byte({7'h21, 1'b0}, 1'b1, "R8 addr after restart");
    send_byte(8'h6B, 1'b1, "R8 byte1");
    send_byte(8'h80, 1'b1, "R8 byte2");
    send_byte(8'h01, 1'b1, "R8 byte3");
    bus_stop();

    // new device address, R2/R3/R4
    dev_addr = 7'h5C; waitq(4);
    bus_start();
    send_byte({7'h21, 1'b0}, 1'b0, "R4 old addr refused");
    bus_stop();
    expect_word(8'h14, 8'h00, 8'hF0);
    bus_start();
    send_byte({7'h5C, 1'b0}, 1'b1, "R2 new addr");
    send_byte(8'h14, 1'b1, "R6 byte1");
    send_byte(8'h00, 1'b1, "R6 byte2");
    send_byte(8'hF0, 1'b1, "R6 byte3");
    bus_stop();
    bus_start();
    send_byte({GADDR, 1'b0}, 1'b1, "R3 global with new addr");
    bus_stop();

    waitq(10);
    check("R8 scoreboard drained", sb.size(), 0);
    check("R9 pulse count", pulses, pushed);
    check("R10 pull released idle", {31'd0, sda_pull}, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule